// File: doc/BRIEF.md
# Load/store address generator

This block turns one 32-bit load/store instruction of the register-offset, pre-indexed class into the facts the pipeline needs. It supports both the scaled and the unscaled variants. The index register value is first shifted or rotated as the instruction asks. The result is then added to or subtracted from the base register value to form the effective address. The block also decides whether that address is written back to the base register. Writeback needs the writeback bit to be set and the instruction's condition to hold against the current status flags.

The decode, the shifter, the condition evaluator and the adder form one combinational pass. The results are captured in an output register on each rising clock edge. The block also reports the access size, the direction, and the index of the base register to update. A flag marks operand choices whose architectural result is undefined. The register file, the memory port and data alignment sit outside the block.

Top module: `lsag_unit`

## Requirements
- R1: While `rst_ni` is low, every output is 0. Reset acts asynchronously.
- R2: Outputs are registered. Each output reflects the inputs sampled at the previous rising edge of `clk_i` and holds steady between edges.
- R3: Instruction bit 23 selects the operation: when it is 1, `addr_o` is base plus shifted index; when it is 0, `addr_o` is base minus shifted index. Both wrap modulo 2^32.
- R4: Bits 6:5 equal to 00 select a left shift of the index by the amount in bits 11:7. An amount of 0 passes the index unchanged, which is the plain register form with bits 11:4 all zero.
- R5: Bits 6:5 equal to 01 select a logical right shift. An amount of 0 means a shift by 32 and yields 0.
- R6: Bits 6:5 equal to 10 select an arithmetic right shift. An amount of 0 yields 32 copies of index bit 31.
- R7: Bits 6:5 equal to 11 select a right rotate. An amount of 0 instead yields the carry flag followed by index bits 31:1.
- R8: `byte_o` equals instruction bit 22 (1 means unsigned byte, 0 means word). `load_o` equals bit 20 (1 means load, 0 means store).
- R9: The condition in bits 31:28 is evaluated against `flags_i` = {N,Z,C,V} (bit 3 is N, bit 0 is V). The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; A N==V; B N!=V; C !Z&(N==V); D Z|(N!=V); E always; F never. Writeback happens only when the condition passes.
- R10: `wb_en_o` is 1 only when all of the following hold: the condition passes, bit 21 is 1, bits 27:24 are 0111, and bit 4 is 0. `wb_idx_o` equals bits 19:16.
- R11: `unpred_o` is 1 when any of the following holds: the base field (bits 19:16) is 15, the index field (bits 3:0) is 15, or the two fields are equal. The address is still produced in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| flags_i | input | 4 | Status flags {N,Z,C,V} |
| addr_o | output | 32 | Effective address |
| byte_o | output | 1 | Byte access (0 = word) |
| load_o | output | 1 | Load (0 = store) |
| wb_en_o | output | 1 | Write the address back to the base register |
| wb_idx_o | output | 4 | Base register index for writeback |
| unpred_o | output | 1 | Operand choice has an undefined result |

## Verification
The carry flag has two uses in the same cycle. The zero-amount rotate shifts it into the top bit of the offset. The condition codes 2 and 3 also test it to gate writeback. The bench provokes this with rotate-by-zero instructions under those conditions, once with carry set and once with carry clear. It judges the address and the writeback enable from the same registered sample. Both outputs must follow the single flag value, so a mismatch in either one shows the carry was routed to only one consumer.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 4;
  localparam int AMT_W   = 5;

  // fixed instruction field positions
  localparam int COND_LSB = 28;
  localparam int CLS_LSB  = 24;
  localparam int ADD_BIT  = 23;
  localparam int BYTE_BIT = 22;
  localparam int WB_BIT   = 21;
  localparam int LOAD_BIT = 20;
  localparam int RN_LSB   = 16;
  localparam int RD_LSB   = 12;
  localparam int AMT_LSB  = 7;
  localparam int KIND_LSB = 5;
  localparam int SEL_BIT  = 4;
  localparam int RM_LSB   = 0;

  localparam logic [3:0]       CLS_CODE = 4'b0111;
  localparam logic [REG_W-1:0] PC_REG   = '1;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef struct packed {
    logic [3:0]       cond;
    logic             add;
    logic             byte_sel;
    logic             wb_req;
    logic             load;
    logic             form_ok;
    logic [REG_W-1:0] rn;
    logic [REG_W-1:0] rm;
    logic [AMT_W-1:0] amt;
    shift_kind_e      kind;
  } ls_fields_t;

  function automatic logic cond_holds(input logic [3:0] code, input nzcv_t f);
    logic r;
    unique case (code)
      4'h0: r = f.z;
      4'h1: r = !f.z;
      4'h2: r = f.c;
      4'h3: r = !f.c;
      4'h4: r = f.n;
      4'h5: r = !f.n;
      4'h6: r = f.v;
      4'h7: r = !f.v;
      4'h8: r = f.c && !f.z;
      4'h9: r = !f.c || f.z;
      4'hA: r = (f.n == f.v);
      4'hB: r = (f.n != f.v);
      4'hC: r = !f.z && (f.n == f.v);
      4'hD: r = f.z || (f.n != f.v);
      4'hE: r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
  import lsag_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output ls_fields_t         fields_o,
  output logic               unpred_o
);
  logic [REG_W-1:0] unused_rd;

  assign unused_rd = instr_i[RD_LSB +: REG_W];

  always_comb begin
    fields_o.cond     = instr_i[COND_LSB +: 4];
    fields_o.add      = instr_i[ADD_BIT];
    fields_o.byte_sel = instr_i[BYTE_BIT];
    fields_o.wb_req   = instr_i[WB_BIT];
    fields_o.load     = instr_i[LOAD_BIT];
    fields_o.rn       = instr_i[RN_LSB +: REG_W];
    fields_o.rm       = instr_i[RM_LSB +: REG_W];
    fields_o.amt      = instr_i[AMT_LSB +: AMT_W];
    fields_o.kind     = shift_kind_e'(instr_i[KIND_LSB +: 2]);
    fields_o.form_ok  = (instr_i[CLS_LSB +: 4] == CLS_CODE) && !instr_i[SEL_BIT];
  end

  // pc as operand or base aliasing index
  assign unpred_o = (fields_o.rn == PC_REG) || (fields_o.rm == PC_REG) ||
                    (fields_o.rn == fields_o.rm);
endmodule

// File: rtl/lsag_cond.sv
module lsag_cond
  import lsag_pkg::*;
(
  input  logic [3:0] cond_i,
  input  nzcv_t      flags_i,
  output logic       pass_o
);
  logic [15:0] pass_tbl;

  for (genvar g = 0; g < 16; g++) begin : g_tbl
    assign pass_tbl[g] = cond_holds(4'(g), flags_i);
  end

  assign pass_o = pass_tbl[cond_i];

  always_comb begin
    if (cond_i == 4'hF) begin
      AST_NEVER_PASSES: assert (!pass_o); // R9
    end
  end
endmodule

// File: rtl/lsag_shift.sv
module lsag_shift
  import lsag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_kind_e       kind_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] value_o
);
  localparam int DBL_W = 2 * DATA_W;

  logic              amt_zero;
  logic [DBL_W-1:0]  rot_dbl;
  logic [DATA_W-1:0] asr_val;

  assign amt_zero = (amt_i == '0);
  assign rot_dbl  = {value_i, value_i} >> amt_i;
  assign asr_val  = $signed(value_i) >>> amt_i;

  always_comb begin
    unique case (kind_i)
      SH_LSL: value_o = value_i << amt_i;
      SH_LSR: value_o = amt_zero ? '0 : (value_i >> amt_i);
      SH_ASR: value_o = amt_zero ? {DATA_W{value_i[DATA_W-1]}} : asr_val;
      default: value_o = amt_zero ? {carry_i, value_i[DATA_W-1:1]} : rot_dbl[DATA_W-1:0];
    endcase
  end

  always_comb begin
    if (kind_i == SH_ROR && amt_zero) begin
      AST_RRX_TOP_IS_CARRY: assert (value_o[DATA_W-1] == carry_i); // R7
    end
    if (kind_i == SH_LSR && amt_zero) begin
      AST_LSR32_ZERO: assert (value_o == '0); // R5
    end
  end
endmodule

// File: rtl/lsag_unit.sv
module lsag_unit
  import lsag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic [DATA_W-1:0]   base_i,
  input  logic [DATA_W-1:0]   index_i,
  input  logic [3:0]          flags_i,
  output logic [DATA_W-1:0]   addr_o,
  output logic                byte_o,
  output logic                load_o,
  output logic                wb_en_o,
  output logic [REG_W-1:0]    wb_idx_o,
  output logic                unpred_o
);
  ls_fields_t        fld;
  nzcv_t             flg;
  logic              unpred_d;
  logic              pass;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] addr_d;
  logic              wb_d;

  assign flg = nzcv_t'(flags_i);

  lsag_decode u_decode (
    .instr_i  (instr_i),
    .fields_o (fld),
    .unpred_o (unpred_d)
  );

  lsag_cond u_cond (
    .cond_i  (fld.cond),
    .flags_i (flg),
    .pass_o  (pass)
  );

  lsag_shift #(.DATA_W(DATA_W)) u_shift (
    .value_i (index_i),
    .amt_i   (fld.amt),
    .kind_i  (fld.kind),
    .carry_i (flg.c),
    .value_o (offset)
  );

  // wraps mod 2^DATA_W
  assign addr_d = fld.add ? (base_i + offset) : (base_i - offset);
  assign wb_d   = pass && fld.wb_req && fld.form_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      byte_o   <= 1'b0;
      load_o   <= 1'b0;
      wb_en_o  <= 1'b0;
      wb_idx_o <= '0;
      unpred_o <= 1'b0;
    end else begin
      addr_o   <= addr_d;
      byte_o   <= fld.byte_sel;
      load_o   <= fld.load;
      wb_en_o  <= wb_d;
      wb_idx_o <= fld.rn;
      unpred_o <= unpred_d;
    end
  end

  AST_WB_NEEDS_WBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> $past(instr_i[WB_BIT])); // R10

  AST_WB_TARGETS_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o == $past(instr_i[RN_LSB +: REG_W]))); // R10

  AST_NEVER_WRITES_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(instr_i[COND_LSB +: 4]) == 4'hF) |-> !wb_en_o); // R9

  AST_PC_BASE_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(instr_i[RN_LSB +: REG_W]) == PC_REG) |-> unpred_o); // R11

  AST_DIR_FOLLOWS_LBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (load_o == $past(instr_i[LOAD_BIT]))); // R8
endmodule

// File: tb/lsag_unit_tb_top.sv
module lsag_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] instr_i;
  logic [31:0] base_i;
  logic [31:0] index_i;
  logic [3:0]  flags_i;
  logic [31:0] addr_o;
  logic        byte_o, load_o, wb_en_o, unpred_o;
  logic [3:0]  wb_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lsag_unit dut_i (
    .clk_i, .rst_ni, .instr_i, .base_i, .index_i, .flags_i,
    .addr_o, .byte_o, .load_o, .wb_en_o, .wb_idx_o, .unpred_o
  );

  typedef struct packed {
    logic [3:0]  cond;
    logic        u, b, w, l;
    logic [3:0]  rn;
    logic [4:0]  amt;
    logic [1:0]  typ;
    logic [3:0]  rm;
    logic [31:0] base, idx;
    logic [3:0]  flags;
    logic [31:0] exp_addr;
    logic        exp_wb, exp_unp;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h1000,32'h20,4'h0,32'h0000_1020,1'b1,1'b0},      // R4 plain form
    '{4'hE,1'b0,1'b1,1'b1,1'b0,4'd1,5'd2,2'd0,4'd2,32'h1000,32'h10,4'h0,32'h0000_0FC0,1'b1,1'b0},      // R3 subtract
    '{4'hE,1'b1,1'b0,1'b1,1'b0,4'd4,5'd31,2'd0,4'd5,32'h0,32'h3,4'h0,32'h8000_0000,1'b1,1'b0},         // R4 max lsl
    '{4'hE,1'b1,1'b1,1'b1,1'b1,4'd1,5'd4,2'd1,4'd2,32'h100,32'hF000_0000,4'h0,32'h0F00_0100,1'b1,1'b0}, // R5
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd1,4'd2,32'h1234,32'hFFFF_FFFF,4'h0,32'h0000_1234,1'b1,1'b0},// R5 by 32
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd4,2'd2,4'd2,32'h0,32'h8000_0000,4'h0,32'hF800_0000,1'b1,1'b0},   // R6
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd2,4'd2,32'h5,32'h8000_0001,4'h0,32'h0000_0004,1'b1,1'b0},   // R6 by 32 neg
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd2,4'd2,32'h5,32'h7FFF_FFFF,4'h0,32'h0000_0005,1'b1,1'b0},   // R6 by 32 pos
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd8,2'd3,4'd2,32'h0,32'hAB,4'h0,32'hAB00_0000,1'b1,1'b0},          // R7 ror
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd3,4'd2,32'h0,32'h3,4'h2,32'h8000_0001,1'b1,1'b0},           // R7 rrx c=1
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd3,4'd2,32'h0,32'h3,4'h0,32'h0000_0001,1'b1,1'b0},           // R7 rrx c=0
    '{4'hE,1'b1,1'b0,1'b1,1'b0,4'd6,5'd0,2'd0,4'd7,32'hFFFF_FFF0,32'h20,4'h0,32'h0000_0010,1'b1,1'b0},  // R3 wrap up
    '{4'hE,1'b0,1'b1,1'b1,1'b0,4'd6,5'd0,2'd0,4'd7,32'h10,32'h20,4'h0,32'hFFFF_FFF0,1'b1,1'b0},         // R3 wrap down
    '{4'h0,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h4,32'h104,1'b1,1'b0},               // R9 EQ pass
    '{4'h0,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h0,32'h104,1'b0,1'b0},               // R9 EQ fail
    '{4'h1,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h0,32'h104,1'b1,1'b0},               // R9 NE
    '{4'h8,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h2,32'h104,1'b1,1'b0},               // R9 HI pass
    '{4'h8,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h6,32'h104,1'b0,1'b0},               // R9 HI fail
    '{4'hA,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h9,32'h104,1'b1,1'b0},               // R9 GE
    '{4'hB,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h8,32'h104,1'b1,1'b0},               // R9 LT
    '{4'hC,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h4,32'h104,1'b0,1'b0},               // R9 GT fail
    '{4'hD,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h1,32'h104,1'b1,1'b0},               // R9 LE
    '{4'hF,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h0,32'h104,1'b0,1'b0},               // R9 never
    '{4'hE,1'b1,1'b0,1'b0,1'b1,4'd1,5'd0,2'd0,4'd2,32'h100,32'h4,4'h0,32'h104,1'b0,1'b0},               // R10 w=0
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd15,5'd0,2'd0,4'd2,32'h100,32'h4,4'h0,32'h104,1'b1,1'b1},              // R11 rn=15
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd3,5'd0,2'd0,4'd3,32'h100,32'h4,4'h0,32'h104,1'b1,1'b1},               // R11 rn=rm
    '{4'hE,1'b1,1'b0,1'b1,1'b1,4'd1,5'd0,2'd0,4'd15,32'h100,32'h4,4'h0,32'h104,1'b1,1'b1},              // R11 rm=15
    '{4'h2,1'b1,1'b0,1'b1,1'b1,4'd9,5'd0,2'd3,4'd2,32'h0,32'h2,4'h2,32'h8000_0001,1'b1,1'b0},           // R7 R9 shared carry
    '{4'h2,1'b1,1'b0,1'b1,1'b1,4'd9,5'd0,2'd3,4'd2,32'h0,32'h2,4'h0,32'h0000_0001,1'b0,1'b0}            // R7 R9 shared carry
  };

  function automatic logic [31:0] mk(input vec_t v);
    return {v.cond, 4'b0111, v.u, v.b, v.w, v.l, v.rn, 4'h0, v.amt, v.typ, 1'b0, v.rm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    instr_i = mk(v);
    base_i  = v.base;
    index_i = v.idx;
    flags_i = v.flags;
  endtask

  task automatic check_vec(input vec_t v, input int n);
    chk($sformatf("R3 R4 R5 R6 R7 addr vec %0d", n), addr_o, v.exp_addr);
    chk($sformatf("R9 R10 wb_en vec %0d", n), 32'(wb_en_o), 32'(v.exp_wb));
    chk($sformatf("R10 wb_idx vec %0d", n), 32'(wb_idx_o), 32'(v.rn));
    chk($sformatf("R11 unpred vec %0d", n), 32'(unpred_o), 32'(v.exp_unp));
    chk($sformatf("R8 byte vec %0d", n), 32'(byte_o), 32'(v.b));
    chk($sformatf("R8 load vec %0d", n), 32'(load_o), 32'(v.l));
  endtask

  task automatic check_zero(input string tag);
    chk({tag, " addr"}, addr_o, 32'h0);
    chk({tag, " flags"}, {26'h0, byte_o, load_o, wb_en_o, unpred_o, 2'b00}, 32'h0);
    chk({tag, " wb_idx"}, 32'(wb_idx_o), 32'h0);
  endtask

  initial begin
    rst_ni  = 1'b0;
    instr_i = mk(VECS[0]);
    base_i  = 32'h1234_5678;
    index_i = 32'h9;
    flags_i = 4'h0;
    repeat (3) @(negedge clk_i);
    check_zero("R1 in reset");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk_i);
      check_vec(VECS[i], i);
    end

    // R10: class bits 27:24 other than 0111
    apply(VECS[0]);
    instr_i[27:24] = 4'b0110;
    @(negedge clk_i);
    chk("R10 wrong class wb_en", 32'(wb_en_o), 32'h0);
    chk("R10 wrong class addr", addr_o, 32'h1020);

    // R10: bit 4 set
    apply(VECS[0]);
    instr_i[4] = 1'b1;
    @(negedge clk_i);
    chk("R10 bit4 wb_en", 32'(wb_en_o), 32'h0);

    // R2: outputs hold between edges, update at the edge
    apply(VECS[1]);
    @(negedge clk_i);
    apply(VECS[3]);
    #5;
    chk("R2 hold addr", addr_o, VECS[1].exp_addr);
    chk("R2 hold byte", 32'(byte_o), 32'(VECS[1].b));
    @(negedge clk_i);
    chk("R2 update addr", addr_o, VECS[3].exp_addr);

    // R1: asynchronous reset mid-run
    apply(VECS[24]);
    @(negedge clk_i);
    chk("R11 before reset", 32'(unpred_o), 32'h1);
    #3 rst_ni = 1'b0;
    #2;
    check_zero("R1 async");
    @(negedge clk_i);
    check_zero("R1 held");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_vec(VECS[24], 24);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule